// File: doc/BRIEF.md
# Down-Spread Triangle Offset Generator

This block produces the digital offset word that a fractional feedback divider subtracts from its nominal divide value, so that the synthesized clock sweeps in a triangle between nominal and 0.5% below nominal. The block runs from the reference clock. A step timer sets the update rate of the ramp. A level counter climbs and descends between zero and a top level. The level is multiplied by a constant step, so the largest offset equals the fixed down-spread depth.

The offset word is unsigned, and its value is the amount to subtract from the nominal divide value. Zero means nominal frequency. A companion indicator reports the slope of the sweep. The spread enable comes from mode decode logic and may change in any cycle. Dropping it returns the output to nominal on the next cycle. Raising it restarts the sweep at its lowest-frequency point, with no reset needed.

The default parameters give 32 updates per triangle period. At a 1 MHz update rate this is close to a 30 kHz modulation.

Top module: `tri_spread_gen`

## Requirements
- R1: During and right after reset, `offset_o` is 0 and `falling_o` is 0.
- R2: After a clock edge that samples `spread_en_i` low, `offset_o` is 0 and `falling_o` is 0.
- R3: After the first edge that samples `spread_en_i` high, `offset_o` equals the full-scale value FS = HALF_STEPS × STEP, with STEP = floor(NOM_DIV × 5 / 1000 / HALF_STEPS). The value holds for STEP_CLKS cycles, and `falling_o` is 0 (rising frequency).
- R4: While enabled, every offset value holds for exactly STEP_CLKS cycles. Consecutive values differ by exactly STEP.
- R5: The offset descends from FS to 0 and then ascends back to FS. It reverses at each extreme without repeating the extreme value, so one triangle period is 2 × HALF_STEPS × STEP_CLKS cycles.
- R6: `falling_o` is 1 while the offset grows, which is the frequency falling. That includes the FS point reached at the end of an ascent. `falling_o` is 0 while the offset shrinks and at the zero point.
- R7: The enable may drop at any point of the sweep. The output is 0 on the next cycle. A later rise of the enable restarts the sweep from the R3 state, without any reset.
- R8: `offset_o` never exceeds FS, and FS never exceeds 0.5% of NOM_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_en_i | input | 1 | Spread enable from mode decode |
| offset_o | output | OFF_W | Unsigned amount to subtract from the nominal divide value |
| falling_o | output | 1 | 1 while the synthesized frequency falls |

## Verification
A wrong level, direction or step count shows up within one update interval (STEP_CLKS cycles) as an offset value that no triangle of this shape can reach, or as a hold of the wrong length. A turnaround error appears at the first extreme, at most HALF_STEPS updates after the enable rises. That is either a doubled extreme value or an overshoot past FS or zero. A direction flag that goes out of step with the level is visible on `falling_o` in the same cycle as the offset it accompanies. Stale state after a disable shows up on the very first cycle of the next enable, because the bench expects exactly FS there.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  typedef enum logic {DIR_RISE = 1'b0, DIR_FALL = 1'b1} ssg_dir_e;

  // offset step per ramp update, floored so full scale stays at or under 0.5%
  function automatic int unsigned ssg_step_size(int unsigned nom_div, int unsigned half_steps);
    return (nom_div * 5 / 1000) / half_steps;
  endfunction
endpackage

// File: rtl/ssg_step_timer.sv
module ssg_step_timer #(
  parameter int unsigned STEP_CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssg_ramp.sv
module ssg_ramp
  import ssg_pkg::*;
#(
  parameter int unsigned HALF_STEPS = 16,
  parameter int unsigned LVL_W      = $clog2(HALF_STEPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [LVL_W-1:0] lvl_o,
  output ssg_dir_e         dir_o
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(HALF_STEPS);

  logic [LVL_W-1:0] lvl_q;
  ssg_dir_e         dir_q;

  // level = down amount in steps; DIR_RISE walks it toward zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= TOP;
      dir_q <= DIR_RISE;
    end else if (!en_i) begin
      lvl_q <= TOP;
      dir_q <= DIR_RISE;
    end else if (tick_i) begin
      if (dir_q == DIR_RISE) begin
        if (lvl_q == '0) begin
          lvl_q <= LVL_W'(1);
          dir_q <= DIR_FALL;
        end else begin
          lvl_q <= lvl_q - 1'b1;
        end
      end else begin
        if (lvl_q == TOP) begin
          lvl_q <= TOP - 1'b1;
          dir_q <= DIR_RISE;
        end else begin
          lvl_q <= lvl_q + 1'b1;
        end
      end
    end
  end

  assign lvl_o = lvl_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/ssg_scale.sv
module ssg_scale
  import ssg_pkg::*;
#(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned STEP  = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  ssg_dir_e         dir_i,
  output logic [OFF_W-1:0] offset_o,
  output logic             falling_o
);
  localparam logic [OFF_W-1:0] STEP_W = OFF_W'(STEP);

  logic [OFF_W-1:0] offset_q;
  logic             falling_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q  <= '0;
      falling_q <= 1'b0;
    end else if (!en_i) begin
      offset_q  <= '0;
      falling_q <= 1'b0;
    end else begin
      offset_q  <= OFF_W'(lvl_i) * STEP_W;
      falling_q <= (dir_i == DIR_FALL);
    end
  end

  assign offset_o  = offset_q;
  assign falling_o = falling_q;
endmodule

// File: rtl/tri_spread_gen.sv
module tri_spread_gen
  import ssg_pkg::*;
#(
  parameter int unsigned NOM_DIV    = 819200,  // nominal divide, 12 fraction bits
  parameter int unsigned HALF_STEPS = 16,
  parameter int unsigned STEP_CLKS  = 3,
  parameter int unsigned OFF_W      = $clog2(ssg_step_size(NOM_DIV, HALF_STEPS) * HALF_STEPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spread_en_i,
  output logic [OFF_W-1:0] offset_o,
  output logic             falling_o
);
  localparam int unsigned STEP  = ssg_step_size(NOM_DIV, HALF_STEPS);
  localparam int unsigned LVL_W = $clog2(HALF_STEPS + 1);

  logic             tick;
  logic [LVL_W-1:0] lvl;
  ssg_dir_e         dir;

  ssg_step_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (spread_en_i),
    .tick_o (tick)
  );

  ssg_ramp #(.HALF_STEPS(HALF_STEPS), .LVL_W(LVL_W)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (spread_en_i),
    .tick_i (tick),
    .lvl_o  (lvl),
    .dir_o  (dir)
  );

  ssg_scale #(.LVL_W(LVL_W), .OFF_W(OFF_W), .STEP(STEP)) u_scale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (spread_en_i),
    .lvl_i     (lvl),
    .dir_i     (dir),
    .offset_o  (offset_o),
    .falling_o (falling_o)
  );
endmodule

// File: rtl/ssg_checker.sv
module ssg_checker #(
  parameter int unsigned NOM_DIV    = 819200,
  parameter int unsigned HALF_STEPS = 16,
  parameter int unsigned OFF_W      = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [OFF_W-1:0] offset_i,
  input logic             falling_i
);
  localparam int unsigned STEP = (NOM_DIV * 5 / 1000) / HALF_STEPS;
  localparam logic [OFF_W-1:0] STEP_W = OFF_W'(STEP);
  localparam logic [OFF_W-1:0] FS_W   = OFF_W'(STEP * HALF_STEPS);

  assert_zero_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (offset_i == '0 && !falling_i));

  assert_start_full_scale_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !$past(en_i)) |=> (offset_i == FS_W && !falling_i));

  assert_single_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(en_i, 2)) |->
      (offset_i == $past(offset_i) || offset_i == $past(offset_i) + STEP_W ||
       offset_i == $past(offset_i) - STEP_W));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_i <= FS_W);
endmodule

bind tri_spread_gen ssg_checker #(
  .NOM_DIV(NOM_DIV), .HALF_STEPS(HALF_STEPS), .OFF_W(OFF_W)
) u_ssg_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (spread_en_i),
  .offset_i  (offset_o),
  .falling_i (falling_o)
);

// File: tb/tb_tri_spread_gen.sv
module tb_tri_spread_gen;
  localparam int unsigned NOM_DIV    = 819200;
  localparam int unsigned HALF_STEPS = 16;
  localparam int unsigned STEP_CLKS  = 3;
  localparam int unsigned STEP       = (NOM_DIV * 5 / 1000) / HALF_STEPS;
  localparam int unsigned FS         = STEP * HALF_STEPS;
  localparam int unsigned OFF_W      = $clog2(FS + 1);
  localparam int unsigned PERIOD     = 2 * HALF_STEPS * STEP_CLKS;

  typedef struct {
    int unsigned off;
    bit          fall;
    string       tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [OFF_W-1:0] offset;
  logic             falling;

  int   n_vec = 0;
  int   n_bad = 0;
  int   run_i = 0;
  exp_t sb_q[$];
  bit   done = 1'b0;

  always #5 clk = ~clk;

  tri_spread_gen #(
    .NOM_DIV(NOM_DIV), .HALF_STEPS(HALF_STEPS), .STEP_CLKS(STEP_CLKS)
  ) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .spread_en_i (en),
    .offset_o    (offset),
    .falling_o   (falling)
  );

  task automatic check(input string tag, input int unsigned act_off, input bit act_fall,
                       input int unsigned exp_off, input bit exp_fall);
    n_vec++;
    if (act_off != exp_off || act_fall != exp_fall) begin
      n_bad++;
      $display("FAIL %s: offset/falling actual %0d/%0d expected %0d/%0d",
               tag, act_off, act_fall, exp_off, exp_fall);
    end
  endtask

  // driver: applies enable for n cycles and pushes the expected output per edge
  task automatic drive(input bit en_v, input int n, input string off_tag);
    for (int c = 0; c < n; c++) begin
      exp_t e;
      @(negedge clk);
      en = en_v;
      @(posedge clk);
      if (!en_v) begin
        e.off = 0; e.fall = 1'b0; e.tag = off_tag;
        run_i = 0;
      end else begin
        int s, t, lvl;
        s   = run_i / STEP_CLKS;
        t   = s % (2 * HALF_STEPS);
        lvl = (t <= HALF_STEPS) ? HALF_STEPS - t : t - HALF_STEPS;
        e.off  = lvl * STEP;
        e.fall = (t > HALF_STEPS) || (t == 0 && s > 0);
        if (s == 0)                                e.tag = "R3";
        else if (lvl == 0 || lvl == HALF_STEPS)    e.tag = "R5";
        else if (e.fall)                           e.tag = "R6";
        else                                       e.tag = "R4";
        run_i++;
      end
      sb_q.push_back(e);
    end
  endtask

  // monitor: compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, offset, falling, e.off, e.fall);
        if (offset > FS) check("R8", offset, falling, FS, falling);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        n_vec++;
        $display("FAIL watchdog: cycles actual %0d expected below 20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int half_cyc, hold_cnt;
    int unsigned prev;
    repeat (3) @(negedge clk);
    check("R1", offset, falling, 0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", offset, falling, 0, 1'b0);

    drive(1'b0, 8, "R2");
    // two full triangles plus a little
    drive(1'b1, 2 * PERIOD + 7, "R3");
    // drop mid-ramp, then restart without reset
    drive(1'b0, 4, "R7");
    drive(1'b1, HALF_STEPS * STEP_CLKS + 5, "R7");
    drive(1'b0, 1, "R7");
    drive(1'b1, 1, "R7");
    drive(1'b0, 2, "R7");
    drive(1'b1, STEP_CLKS * 4, "R7");
    @(negedge clk);

    // R5: time from restart to bottom reversal, measured at the ports
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    half_cyc = 0;
    do begin
      @(negedge clk);
      half_cyc++;
    end while (offset != 0 && half_cyc < 1000);
    check("R5", half_cyc, 1'b0, HALF_STEPS * STEP_CLKS + 1, 1'b0);
    // R4: hold length at the zero point
    hold_cnt = 0;
    prev = offset;
    while (offset == prev && hold_cnt < 1000) begin
      @(negedge clk);
      hold_cnt++;
    end
    check("R4", hold_cnt, falling, STEP_CLKS, 1'b1);
    check("R6", offset, falling, STEP, 1'b1);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2", offset, falling, 0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule